// File: doc/BRIEF.md
# Dual-Counter Timer Clock Unit

This block feeds two 16-bit timer/counters. One 5-bit programmable divider shared by both slows the system clock. Each counter has its own 3-bit source code that picks what makes it advance:

- the divided system clock;
- rising edges of an external event pin;
- the divided clock gated by the level of that same pin (pulse accumulation);
- rising edges of a slow clock input.

The chosen source becomes a one-cycle count-enable pulse. The counter adds one on each pulse.

Software reaches the block over a small register bus. Four word addresses hold the divider ratio, the pair of source codes, and the two count values. There is no separate run bit: a counter runs as soon as a valid non-zero source code is written for it, and it stops when the code is cleared. The event pin and the slow clock are asynchronous to the system clock. Each passes through a two-flop synchroniser before edge or level detection.

Top module: `tmr_clock_unit`

## Requirements
- R1: After reset, the divider register (address 0) and the source register (address 1) read zero, and both count-enable outputs stay low.
- R2: Unused register bits read as zero. The divider register keeps only bits 4:0. The source register keeps only bits 5:0, with counter A's code in bits 2:0 and counter B's code in bits 5:3.
- R3: With source code 001 and divider value P, a counter's enable pulses exactly every P+1 system clocks. P=0 gives an enable on every cycle.
- R4: Writing the divider register restarts the divide sequence. Take the cycle of that write as cycle 0. The next enables then fall on the cycles that are multiples of P+1.
- R5: Source code 000 and the reserved codes 101, 110 and 111 produce no enable. The count value then holds.
- R6: With source code 010, the counter advances once per rising edge of the event pin, after a two-flop synchroniser.
- R7: With source code 011, the counter advances on each divided-clock enable while the synchronised event pin is high. It does not advance while the pin is low.
- R8: With source code 100, the counter advances once per rising edge of the synchronised slow clock input.
- R9: A counter at 0xFFFF that receives an enable wraps to 0x0000.
- R10: A bus write to a count register (A at address 2, B at address 3) overrides an increment in the same cycle. The written value reads back on the next cycle.
- R11: The two counters are independent: each follows only its own source field.
- R12: Reset does not clear the count registers. They keep the last written or counted value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 divider, 1 source, 2 count A, 3 count B |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tb_in | input | 1 | Asynchronous external event / gate pin |
| slow_in | input | 1 | Asynchronous slow clock input |
| cnt_en_o | output | 2 | Per-counter count-enable pulses (bit 0 = A, bit 1 = B) |

## Verification
The bench builds the block with its default parameters: a 5-bit divider, 16-bit counters and two synchroniser stages. With these defaults the whole divisor range from 1 to 32 is covered by short windows. Random divider values and window lengths are checked against a closed-form count of the enables. A count of 0xFFFF can be loaded directly, so the wrap case takes one cycle instead of 65536. Because the synchroniser depth is two, event and slow-clock pulses three or four cycles wide are enough to give exact edge counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CNT  = 2;
  localparam int SRC_W    = 3;
  localparam int ADDR_W   = 2;

  localparam logic [SRC_W-1:0] SRC_OFF   = 3'd0;
  localparam logic [SRC_W-1:0] SRC_DIV   = 3'd1;
  localparam logic [SRC_W-1:0] SRC_EVENT = 3'd2;
  localparam logic [SRC_W-1:0] SRC_ACCUM = 3'd3;
  localparam logic [SRC_W-1:0] SRC_SLOW  = 3'd4;

  localparam logic [ADDR_W-1:0] ADR_DIV  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CNTA = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CNTB = 2'd3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ratio,
  input  logic            restart,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == ratio);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic [SRC_W-1:0] src,
  input  logic             div_tick,
  input  logic             ev_rise,
  input  logic             ev_level,
  input  logic             slow_rise,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             en_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    unique case (src)
      SRC_DIV:   en_o = div_tick;
      SRC_EVENT: en_o = ev_rise;
      SRC_ACCUM: en_o = div_tick & ev_level;
      SRC_SLOW:  en_o = slow_rise;
      default:   en_o = 1'b0;
    endcase
  end

  always_comb begin
    if (wr_en)     count_d = wr_data;
    else if (en_o) count_d = count_q + 1'b1;
    else           count_d = count_q;
  end

  // Count value is deliberately left out of reset.
  always_ff @(posedge clk) begin
    count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_clock_unit.sv
module tmr_clock_unit
  import tmr_pkg::*;
#(
  parameter int PS_W        = 5,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tb_in,
  input  logic              slow_in,
  output logic [NUM_CNT-1:0] cnt_en_o
);
  localparam int SEL_W = NUM_CNT * SRC_W;

  logic [PS_W-1:0]  ps_q, ps_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             wr_div, wr_src;
  logic             div_tick, ev_rise, ev_level, slow_rise, slow_level;
  logic [CNT_W-1:0] cnt_val [NUM_CNT];

  assign wr_div = bus_we && (bus_addr == ADR_DIV);
  assign wr_src = bus_we && (bus_addr == ADR_SRC);

  always_comb begin
    ps_d  = wr_div ? bus_wdata[PS_W-1:0]  : ps_q;
    sel_d = wr_src ? bus_wdata[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      sel_q <= '0;
    end else begin
      ps_q  <= ps_d;
      sel_q <= sel_d;
    end
  end

  tmr_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ratio(ps_q), .restart(wr_div), .tick(div_tick)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ev_sync (
    .clk(clk), .rst_n(rst_n), .async_i(tb_in), .level_o(ev_level), .rise_o(ev_rise)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk(clk), .rst_n(rst_n), .async_i(slow_in), .level_o(slow_level), .rise_o(slow_rise)
  );

  logic unused_slow_level;
  assign unused_slow_level = slow_level;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic wr_cnt;
    assign wr_cnt = bus_we && (bus_addr == ADR_CNTA + ADDR_W'(i));
    tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .src      (sel_q[i*SRC_W +: SRC_W]),
      .div_tick (div_tick),
      .ev_rise  (ev_rise),
      .ev_level (ev_level),
      .slow_rise(slow_rise),
      .wr_en    (wr_cnt),
      .wr_data  (bus_wdata),
      .en_o     (cnt_en_o[i]),
      .count_o  (cnt_val[i])
    );
  end

  always_comb begin
    unique case (bus_addr)
      ADR_DIV:  bus_rdata = CNT_W'(ps_q);
      ADR_SRC:  bus_rdata = CNT_W'(sel_q);
      ADR_CNTA: bus_rdata = cnt_val[0];
      default:  bus_rdata = cnt_val[1];
    endcase
  end
endmodule

// File: rtl/tmr_clock_unit_chk.sv
module tmr_clock_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [1:0]  cnt_en_o,
  input logic [4:0]  ps_q,
  input logic [5:0]  sel_q,
  input logic [15:0] cnt_a,
  input logic [15:0] cnt_b
);
  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2) |=> (cnt_a == $past(bus_wdata)));

  // R9
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_addr == 2'd2) && cnt_en_o[0]) |=> (cnt_a == 16'($past(cnt_a) + 16'd1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_addr == 2'd3) && !cnt_en_o[1]) |=> $stable(cnt_b));

  // R5
  stop_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[2:0] == 3'd0 || sel_q[2:0] > 3'd4) |-> !cnt_en_o[0]);

  // R11
  stop_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[5:3] == 3'd0 || sel_q[5:3] > 3'd4) |-> !cnt_en_o[1]);

  // R3
  fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_q == 5'd0 && sel_q[2:0] == 3'd1) |-> cnt_en_o[0]);
endmodule

bind tmr_clock_unit tmr_clock_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_en_o(cnt_en_o), .ps_q(ps_q), .sel_q(sel_q),
  .cnt_a(cnt_val[0]), .cnt_b(cnt_val[1])
);

// File: tb/tb_tmr_clock_unit.sv
module tb_tmr_clock_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tb_in;
  logic        slow_in;
  logic [1:0]  cnt_en_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_clock_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_in(tb_in),
    .slow_in(slow_in), .cnt_en_o(cnt_en_o)
  );

  // Enables in a window of n edges after (divider write, count write).
  function automatic int exp_div(int ps, int n);
    int d = ps + 1;
    return (n + 1) / d - ((d == 1) ? 1 : 0);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic div_trial(string req, logic [1:0] cadr, int ps, int n);
    logic [15:0] v;
    wr(2'd0, 16'(ps));
    wr(cadr, 16'h0000);
    wait_cyc(n);
    rd(cadr, v);
    check(req, v, 16'(exp_div(ps, n)));
  endtask

  task automatic pulse(ref logic sig, input int hi, input int lo);
    sig = 1'b1; repeat (hi) @(negedge clk);
    sig = 1'b0; repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w;
    int k, last;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    tb_in = 1'b0; slow_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 divider", v, 16'h0000);
    rd(2'd1, v); check("R1 source", v, 16'h0000);
    check("R1 enables", {14'd0, cnt_en_o}, 16'h0000);

    // R12 counts survive reset
    wr(2'd2, 16'hA5A5); wr(2'd3, 16'h5A5A);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(2'd2, v); check("R12 count A", v, 16'hA5A5);
    rd(2'd3, v); check("R12 count B", v, 16'h5A5A);

    // R2 reserved bits; both codes 7 (reserved) -> R5
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 divider", v, 16'h001F);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R2 source", v, 16'h003F);
    wait_cyc(40);
    rd(2'd2, v); check("R5 reserved A", v, 16'hA5A5);
    rd(2'd3, v); check("R5 reserved B", v, 16'h5A5A);
    for (int c = 5; c < 8; c++) begin
      wr(2'd1, 16'(c));
      wait_cyc(10);
      rd(2'd2, v); check("R5 reserved code", v, 16'hA5A5);
    end
    wr(2'd1, 16'h0000); wait_cyc(10);
    rd(2'd2, v); check("R5 stop code", v, 16'hA5A5);

    // R3 / R4 directed and random divider windows on counter A
    wr(2'd1, 16'h0001);
    div_trial("R3 divide by 1", 2'd2, 0, 25);
    div_trial("R4 divide by 32", 2'd2, 31, 100);
    for (int t = 0; t < 10; t++)
      div_trial("R4 random divider", 2'd2, int'($urandom % 32), 20 + int'($urandom % 150));
    rd(2'd3, v); check("R11 B untouched", v, 16'h5A5A);

    // R3 pulse spacing with P=3
    wr(2'd0, 16'd3);
    last = -1;
    for (int i = 0; i < 40; i++) begin
      if (cnt_en_o[0]) begin
        if (last >= 0) check("R3 spacing", 16'(i - last), 16'd4);
        last = i;
      end
      @(negedge clk);
    end

    // R6 external event edges
    wr(2'd1, 16'h0002); wr(2'd2, 16'h0000);
    k = 3 + int'($urandom % 6);
    for (int i = 0; i < k; i++) pulse(tb_in, 3, 3);
    wait_cyc(4);
    rd(2'd2, v); check("R6 event count", v, 16'(k));

    // R7 pulse accumulate: low gate then high gate
    wr(2'd1, 16'h0003); wr(2'd0, 16'd2); wr(2'd2, 16'h0000);
    wait_cyc(30);
    rd(2'd2, v); check("R7 gate low", v, 16'h0000);
    tb_in = 1'b1; wait_cyc(5);
    div_trial("R7 gate high", 2'd2, 2, 47);
    tb_in = 1'b0; wait_cyc(5);
    rd(2'd2, w); wait_cyc(20);
    rd(2'd2, v); check("R7 gate closed", v, w);

    // R8 slow clock edges
    wr(2'd1, 16'h0004); wr(2'd2, 16'h0000);
    k = 2 + int'($urandom % 7);
    for (int i = 0; i < k; i++) pulse(slow_in, 4, 4);
    wait_cyc(4);
    rd(2'd2, v); check("R8 slow count", v, 16'(k));

    // R10 write priority and R9 wrap, every-cycle counting
    wr(2'd0, 16'd0); wr(2'd1, 16'h0001);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R10 write wins", v, 16'hFFFF);
    wait_cyc(1);
    rd(2'd2, v); check("R9 wrap", v, 16'h0000);
    for (int t = 0; t < 4; t++) begin
      w = 16'($urandom);
      wr(2'd2, w);
      rd(2'd2, v); check("R10 random write", v, w);
      wait_cyc(1);
      rd(2'd2, v); check("R10 next increment", v, 16'(w + 16'd1));
    end

    // R11 counter B: event mode while A divides
    wr(2'd1, 16'h0011); wr(2'd3, 16'h0000);
    for (int i = 0; i < 4; i++) pulse(tb_in, 3, 3);
    wait_cyc(4);
    rd(2'd3, v); check("R11 B event", v, 16'd4);
    // B divided clock, A stopped
    wr(2'd1, 16'h0008);
    rd(2'd2, w);
    div_trial("R11 B divider", 2'd3, 5, 61);
    rd(2'd2, v); check("R11 A stopped", v, w);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule